// File: doc/BRIEF.md
# Codec Byte Stream Serial Port

This block carries 8-bit audio samples between a processor's register interface and an external codec over a synchronous serial line. Software writes bytes into a 16-entry transmit queue through one 8-bit data port and reads received bytes from a 16-entry receive queue through the same port. A shift engine sends one byte and receives one byte in every byte period. Bits go out most significant bit first, on a bit clock divided down from the system clock. A frame-sync output marks the first bit of each byte.

The port runs only while `codec_sel` is high, which stands for the serial-select control bit choosing the codec function. While it runs, it emits a one-cycle interrupt after every eighth byte it transfers, so software can service eight bytes per interrupt. At the intended 64 kbit/s line rate the byte rate is 8000 bytes per second and the interrupt rate is 1 kHz. `BIT_DIV` sets the number of system clocks per bit; for example, 1536 at 98.304 MHz gives that line rate. Empty and full flags for both queues are brought out for polling.

The engine is a three-state machine:
- ST_OFF: idle while disabled.
- ST_START: one cycle that loads the first byte.
- ST_SHIFT: continuous streaming.

Transitions:
- ST_OFF→ST_START on enable.
- ST_START→ST_SHIFT when enable is still high.
- ST_SHIFT→ST_SHIFT while enabled. Each byte boundary reloads the transmit shifter without leaving the state.
- Any state→ST_OFF when `codec_sel` drops.

Top module: `codec_byte_port`

## Requirements
- R1: After reset both queues report empty and not full, `irq` is low, and `sdout`, `sclk` and `fsync` are low.
- R2: A cycle with `wr_en` high pushes `wr_data` into the transmit queue unless it is full. A write to a full queue is discarded and never sent.
- R3: `rd_data` shows the oldest received byte whenever `rx_empty` is low. A cycle with `rd_en` high removes that byte.
- R4: While `codec_sel` is low the transmit queue is not drained, nothing is received, `sclk` and `fsync` stay low, and `irq` never pulses.
- R5: Each byte is sent most significant bit first. `fsync` is high exactly during the first bit period of every byte, and `sdout` is stable for the whole bit period.
- R6: A bit period lasts `BIT_DIV` clocks, with `sclk` high for its first `BIT_DIV/2` clocks. `sdin` is sampled in the last clock of the period. Consecutive bytes follow with no gap, so a byte lasts 8×`BIT_DIV` clocks.
- R7: If the transmit queue is empty at a byte boundary, the byte sent is 0x00.
- R8: If the receive queue is full when a byte completes, that byte is dropped and the queued bytes are unchanged.
- R9: `irq` is a one-cycle pulse after every eighth completed byte. Its byte count restarts from zero each time the port is enabled.
- R10: Each queue holds 16 bytes and delivers them in the order they entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| codec_sel | input | 1 | Serial-select bit choosing the codec function; enables the port |
| wr_en | input | 1 | Data register write strobe (push to transmit queue) |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Data register read strobe (pop from receive queue) |
| rd_data | output | 8 | Oldest received byte |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| sdin | input | 1 | Serial data from the codec |
| sdout | output | 1 | Serial data to the codec |
| sclk | output | 1 | Bit clock to the codec |
| fsync | output | 1 | Frame sync, high during the first bit of each byte |
| irq | output | 1 | Service interrupt, one pulse per eight bytes |

## Verification
After `codec_sel` rises, the first bit appears two clocks later: one clock to reach ST_START and one to load the shifter. A received byte lands in the queue on the clock edge that ends its last bit period, and `irq` rises on that same edge. Both are therefore visible at the following falling edge. Queue flags change one edge after a write or read strobe. The bench drives every input on falling edges and samples at falling edges. For the windows it waits out, it counts clocks from these latencies, so it never samples on the edge where a value changes. The serial line is looped back, so every received byte can be predicted from the written bytes. Serial bits are captured at each rising bit clock.

// File: rtl/codec_port_pkg.sv
package codec_port_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_START = 2'd1,
        ST_SHIFT = 2'd2
    } port_state_t;

endpackage

// File: rtl/codec_fifo.sv
module codec_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                count <= count + 1'b1;
            end else if (do_pop && !do_push) begin
                count <= count - 1'b1;
            end
        end
    end

    always_comb begin
        dout  = mem[rptr];
        empty = (count == '0);
        full  = (count == CNT_FULL);
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(count));

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/codec_shifter.sv
module codec_shifter
    import codec_port_pkg::*;
#(
    parameter int W         = 8,
    parameter int BIT_DIV   = 1536,
    parameter int IRQ_BYTES = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         tx_avail,
    input  logic [W-1:0] tx_byte,
    output logic         tx_pop,
    output logic         rx_push,
    output logic [W-1:0] rx_byte,
    input  logic         sdin,
    output logic         sdout,
    output logic         sclk,
    output logic         fsync,
    output logic         irq
);
    localparam int DCW = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;
    localparam int BCW = $clog2(W);
    localparam int ICW = $clog2(IRQ_BYTES);
    localparam logic [DCW-1:0] DIV_LAST = DCW'(BIT_DIV - 1);
    localparam logic [DCW-1:0] DIV_HALF = DCW'(BIT_DIV / 2);
    localparam logic [BCW-1:0] BIT_LAST = BCW'(W - 1);
    localparam logic [ICW-1:0] IRQ_LAST = ICW'(IRQ_BYTES - 1);

    port_state_t    state, state_nx;
    logic [DCW-1:0] div_cnt;
    logic [BCW-1:0] bit_cnt;
    logic [ICW-1:0] byte_cnt;
    logic [W-1:0]   tx_sh, rx_sh, load_val;
    logic           irq_q, tick, last_tick, load;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        unique case (state)
            ST_OFF:   state_nx = enable ? ST_START : ST_OFF;
            ST_START: state_nx = enable ? ST_SHIFT : ST_OFF;
            ST_SHIFT: state_nx = enable ? ST_SHIFT : ST_OFF;
            default:  state_nx = ST_OFF;
        endcase
    end

    // strobes between the divider, the shifters and the queues
    always_comb begin
        tick      = (state == ST_SHIFT) && enable && (div_cnt == DIV_LAST);
        last_tick = tick && (bit_cnt == BIT_LAST);
        load      = ((state == ST_START) && enable) || last_tick;
        tx_pop    = load && tx_avail;
        load_val  = tx_avail ? tx_byte : '0;
        rx_byte   = {rx_sh[W-2:0], sdin};
        rx_push   = last_tick;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt  <= '0;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            irq_q    <= 1'b0;
        end else begin
            if ((state != ST_SHIFT) || !enable) begin
                div_cnt <= '0;
                bit_cnt <= '0;
            end else begin
                div_cnt <= tick ? '0 : div_cnt + 1'b1;
                if (tick) begin
                    bit_cnt <= last_tick ? '0 : bit_cnt + 1'b1;
                end
            end
            if (state == ST_OFF) begin
                byte_cnt <= '0;
            end else if (last_tick) begin
                byte_cnt <= (byte_cnt == IRQ_LAST) ? '0 : byte_cnt + 1'b1;
            end
            irq_q <= last_tick && (byte_cnt == IRQ_LAST);
            if (load) begin
                tx_sh <= load_val;
            end else if (tick) begin
                tx_sh <= {tx_sh[W-2:0], 1'b0};
            end
            if (tick) begin
                rx_sh <= rx_byte;
            end
        end
    end

    // outputs
    always_comb begin
        sdout = (state == ST_SHIFT) ? tx_sh[W-1] : 1'b0;
        sclk  = (state == ST_SHIFT) && (div_cnt < DIV_HALF);
        fsync = (state == ST_SHIFT) && (bit_cnt == '0);
        irq   = irq_q && enable;
    end

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // R6
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SHIFT) && enable && (div_cnt != DIV_LAST))
            |=> ($stable(bit_cnt) && $stable(tx_sh)));

    // R5
    pop_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> (fsync || (state == ST_OFF)));

endmodule

// File: rtl/codec_byte_port.sv
module codec_byte_port #(
    parameter int W         = 8,
    parameter int DEPTH     = 16,
    parameter int BIT_DIV   = 1536,
    parameter int IRQ_BYTES = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         codec_sel,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         tx_empty,
    output logic         tx_full,
    output logic         rx_empty,
    output logic         rx_full,
    input  logic         sdin,
    output logic         sdout,
    output logic         sclk,
    output logic         fsync,
    output logic         irq
);
    logic [W-1:0] tx_head, rx_byte;
    logic         tx_pop, rx_push;

    codec_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_en),
        .din   (wr_data),
        .pop   (tx_pop),
        .dout  (tx_head),
        .empty (tx_empty),
        .full  (tx_full)
    );

    codec_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .din   (rx_byte),
        .pop   (rd_en),
        .dout  (rd_data),
        .empty (rx_empty),
        .full  (rx_full)
    );

    codec_shifter #(.W(W), .BIT_DIV(BIT_DIV), .IRQ_BYTES(IRQ_BYTES)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (codec_sel),
        .tx_avail (!tx_empty),
        .tx_byte  (tx_head),
        .tx_pop   (tx_pop),
        .rx_push  (rx_push),
        .rx_byte  (rx_byte),
        .sdin     (sdin),
        .sdout    (sdout),
        .sclk     (sclk),
        .fsync    (fsync),
        .irq      (irq)
    );

endmodule

// File: tb/sim_codec_byte_port.sv
module sim_codec_byte_port;
    localparam int BD       = 4;
    localparam int DEPTH    = 16;
    localparam int BYTE_CYC = 8 * BD;

    logic       clk = 1'b0, rst_n = 1'b0, codec_sel = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tx_empty, tx_full, rx_empty, rx_full;
    logic       sdin, sdout, sclk, fsync, irq;

    assign sdin = sdout;   // loopback
    always #4 clk = ~clk;  // 125 MHz

    codec_byte_port #(.W(8), .DEPTH(DEPTH), .BIT_DIV(BD), .IRQ_BYTES(8)) u0 (
        .clk(clk), .rst_n(rst_n), .codec_sel(codec_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
        .sdin(sdin), .sdout(sdout), .sclk(sclk), .fsync(fsync), .irq(irq)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [7:0] q1 [DEPTH];
    logic [7:0] q2 [DEPTH];

    // monitor: observation only
    int cyc = 0, irq_cnt = 0, irq_t = -1, irq_gap = 0, sclk_rises = 0, cap_bits = 0, cap_n = 0;
    bit irq_prev = 1'b0, irq_double = 1'b0, sclk_prev = 1'b0;
    logic [7:0] cap_sr = 8'h00, cap0 = 8'h00;

    always @(negedge clk) begin
        cyc++;
        if (irq) begin
            if (irq_prev) irq_double = 1'b1;
            irq_cnt++;
            if (irq_t >= 0) irq_gap = cyc - irq_t;
            irq_t = cyc;
        end
        irq_prev = irq;
        if (sclk && !sclk_prev) begin
            sclk_rises++;
            if (fsync) cap_bits = 0;
            cap_sr = {cap_sr[6:0], sdout};
            cap_bits++;
            if (cap_bits == 8 && cap_n == 0) begin
                cap0  = cap_sr;
                cap_n = 1;
            end
        end
        sclk_prev = sclk;
    end

    function automatic logic [7:0] exp_stream(int idx);
        return (idx < DEPTH) ? q1[idx] : 8'h00;
    endfunction

    function automatic int exp_irqs(int nbytes);
        return nbytes / 8;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(logic [7:0] b);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic pop(output logic [7:0] b);
        b     = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        logic [7:0] got;
        int n, base, s0;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(tx_empty == 1'b1, "R1", tx_empty, 1);
        chk(rx_empty == 1'b1, "R1", rx_empty, 1);
        chk(tx_full  == 1'b0, "R1", tx_full, 0);
        chk(rx_full  == 1'b0, "R1", rx_full, 0);
        chk(irq == 1'b0 && fsync == 1'b0 && sclk == 1'b0, "R1", {irq, fsync, sclk}, 0);
        chk(sdout == 1'b0, "R1", sdout, 0);

        // fill transmit queue while disabled (random nonzero bytes)
        for (int i = 0; i < DEPTH; i++) begin
            q1[i] = 8'($urandom_range(255, 1));
            push(q1[i]);
            if (i == DEPTH - 2) chk(tx_full == 1'b0, "R10", tx_full, 0);
        end
        chk(tx_full == 1'b1, "R10", tx_full, 1);
        push(8'hEE);  // R2: dropped, must never be sent
        chk(tx_full == 1'b1, "R2", tx_full, 1);

        // R4 disabled: nothing moves
        repeat (100) @(negedge clk);
        chk(tx_full == 1'b1, "R4", tx_full, 1);
        chk(rx_empty == 1'b1, "R4", rx_empty, 1);
        chk(irq_cnt == 0, "R4", irq_cnt, 0);
        chk(sclk_rises == 0, "R4", sclk_rises, 0);

        // stream with loopback and prompt reads
        codec_sel = 1'b1;
        n = 0;
        for (int t = 0; t < 3000 && n < 24; t++) begin
            if (!rx_empty) begin
                pop(got);
                if (n < DEPTH)       chk(got == exp_stream(n), "R10", got, exp_stream(n));
                else if (n == DEPTH) chk(got == exp_stream(n), "R2", got, exp_stream(n));
                else                 chk(got == exp_stream(n), "R7", got, exp_stream(n));
                n++;
            end else begin
                @(negedge clk);
            end
        end
        chk(n == 24, "R3", n, 24);
        repeat (3) @(negedge clk);
        chk(irq_cnt == exp_irqs(24), "R9", irq_cnt, exp_irqs(24));
        chk(irq_double == 1'b0, "R9", irq_double, 0);
        chk(irq_gap == BYTE_CYC * 8, "R6", irq_gap, BYTE_CYC * 8);
        chk(cap0 == q1[0], "R5", cap0, q1[0]);
        chk(tx_empty == 1'b1, "R7", tx_empty, 1);

        // disable and check silence
        codec_sel = 1'b0;
        repeat (2) @(negedge clk);
        base = irq_cnt;
        s0   = sclk_rises;
        repeat (300) @(negedge clk);
        chk(irq_cnt == base, "R4", irq_cnt, base);
        chk(sclk_rises == s0, "R4", sclk_rises, s0);
        for (int t = 0; t < 40 && !rx_empty; t++) pop(got);
        chk(rx_empty == 1'b1, "R3", rx_empty, 1);

        // receive overflow: 20 bytes arrive, no reads
        for (int i = 0; i < DEPTH; i++) begin
            q2[i] = 8'($urandom_range(255, 1));
            push(q2[i]);
        end
        codec_sel = 1'b1;
        base = irq_cnt;
        repeat (20 * BYTE_CYC + 10) @(negedge clk);
        chk(rx_full == 1'b1, "R8", rx_full, 1);
        chk(irq_cnt - base == exp_irqs(20), "R9", irq_cnt - base, exp_irqs(20));
        codec_sel = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < DEPTH; i++) begin
            pop(got);
            chk(got == q2[i], "R8", got, q2[i]);
        end
        chk(rx_empty == 1'b1, "R8", rx_empty, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            $display("FAIL watchdog (R1..all): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
            $finish;
        end
    end

endmodule